// File: doc/BRIEF.md
# Three-Level Hardware Loop Sequencer

This block steers the instruction fetch address so that up to three loops can repeat without any branch instruction. Every cycle the current fetch address is compared with three programmable loop-end addresses. When an armed end matches and the counter tied to it still holds a nonzero count, the block sends the fetch unit back to that level's start address and counts the repetition down by one. When the count is already zero, fetch falls through to the next sequential instruction and the counter is refilled from its reload register, ready for the next pass of an enclosing loop.

Each level has a start address, an end address, a repetition counter and a reload register. A 12-bit control word arms each loop end and links it to any one of the three counters. Software sets the block up through one write port, using plain per-register select codes or two kinds of quick-setup code. The multi-instruction kind places the loop start right after the current instruction and loads the count in one write. The single-instruction kind also places the loop end on that same instruction. A combinational read port returns any register.

Top module: `loop_sequencer`

## Requirements
- R1: After reset every start, end, counter, reload and control register reads zero, and the next address is the current address plus STEP (8 by default).
- R2: A write with select code 0-2 (start of level n = code), 4-6 (end), 8-10 (counter), 12-14 (reload) or 16 (control) stores the data, and the same code on the read port returns it. Only control bits 11:0 are kept and the rest read zero.
- R3: When no armed loop end equals the current address, the next address is the current address plus STEP and no counter changes.
- R4: When an armed end equals the current address and its linked counter is nonzero, the next address is that level's start address and the counter is one lower after the clock edge.
- R5: When an armed end matches and its linked counter is zero, the next address is the current address plus STEP and the counter takes its reload register's value at the clock edge.
- R6: In the control word, level n uses bits 4n+2:4n as the counter link and bit 4n+3 as its enable. Link 001 picks counter 0, 010 counter 1 and 011 counter 2, so any end may drive any counter.
- R7: An end whose enable bit is clear, or whose link is 000 or 1xx, never redirects and never touches a counter.
- R8: When several armed ends match in the same cycle, only the lowest-numbered level acts. Only its counter changes, and only its start is used.
- R9: Select code 20+n loads level n's start with the current address plus STEP and writes the data to both its reload register and its counter. Level n's end is unchanged.
- R10: Select code 24+n does the same as R9 and also sets level n's end to the current address plus STEP, so the loop body is one instruction.
- R11: A register write to a counter in the same cycle as a loop action on it wins. Writes with level field 3, control codes 17-19, or codes 28-31 change nothing, and reads of codes without a register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | AW | Address of the instruction being fetched this cycle |
| nextPc | output | AW | Address to fetch next cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 5 | Write select code (group in bits 4:2, level in bits 1:0) |
| wrData | input | DW | Write data |
| rdSel | input | 5 | Read select code, same encoding as wrSel |
| rdData | output | DW | Read data for rdSel, combinational |

## Verification
A wrong comparator, link decode or priority choice shows up at nextPc in the same cycle that pc reaches a loop end, as a missing, extra or misdirected jump. A counter that is decremented, reloaded or left alone wrongly is visible on the read port one clock edge later. It also changes how many times the loop repeats, so the bench reads counters after each loop action and counts the redirects taken until fall-through. Quick-setup codes are checked by reading back start, end, reload and counter and then running the loop that they define.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;
  localparam int LEVELS  = 3;
  localparam int FIELD_W = 4;
  localparam int CTRL_W  = LEVELS * FIELD_W;
  localparam int SEL_W   = 5;

  typedef enum logic [2:0] {
    GRP_START       = 3'd0,
    GRP_END         = 3'd1,
    GRP_COUNT       = 3'd2,
    GRP_RELOAD      = 3'd3,
    GRP_CTRL        = 3'd4,
    GRP_FAST_MULTI  = 3'd5,
    GRP_FAST_SINGLE = 3'd6,
    GRP_NONE        = 3'd7
  } regGroup_e;

  // strobes from the compare/priority logic to the register datapath
  typedef struct packed {
    logic       redirect;
    logic       decCnt;
    logic       reloadCnt;
    logic [1:0] level;
    logic [1:0] cntIdx;
  } seqStrobe_t;
endpackage

// File: rtl/lpseq_ctrl.sv
module lpseq_ctrl
  import lpseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic [AW-1:0]             pc,
  input  logic [LEVELS-1:0][AW-1:0] endAddr,
  input  logic [LEVELS-1:0][CW-1:0] cnt,
  input  logic [CTRL_W-1:0]         ctrlReg,
  output seqStrobe_t                strb
);
  logic [LEVELS-1:0]      armed;
  logic [LEVELS-1:0][2:0] linkCode;
  logic [LEVELS-1:0][1:0] linkIdx;
  logic                   found;
  logic                   cntZero;

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : gLevel
      assign linkCode[g] = ctrlReg[FIELD_W*g +: 3];
      assign linkIdx[g]  = linkCode[g][1:0] - 2'd1;
      // link 000 and 1xx leave the end inactive
      assign armed[g]    = ctrlReg[FIELD_W*g + 3] && !linkCode[g][2] &&
                           (linkCode[g][1:0] != 2'd0) && (pc == endAddr[g]);
    end
  endgenerate

  always_comb begin
    strb  = '0;
    found = 1'b0;
    for (int l = 0; l < LEVELS; l++) begin
      if (armed[l] && !found) begin
        found       = 1'b1;
        strb.level  = 2'(l);
        strb.cntIdx = linkIdx[l];
      end
    end
    cntZero        = (cnt[strb.cntIdx] == '0);
    strb.redirect  = found && !cntZero;
    strb.decCnt    = found && !cntZero;
    strb.reloadCnt = found && cntZero;
  end
endmodule

// File: rtl/lpseq_regs.sv
module lpseq_regs
  import lpseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int DW   = 32,
  parameter int STEP = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             pc,
  input  logic                      wrEn,
  input  logic [SEL_W-1:0]          wrSel,
  input  logic [DW-1:0]             wrData,
  input  logic [SEL_W-1:0]          rdSel,
  input  seqStrobe_t                strb,
  output logic [AW-1:0]             nextPc,
  output logic [DW-1:0]             rdData,
  output logic [LEVELS-1:0][AW-1:0] endAddr,
  output logic [LEVELS-1:0][CW-1:0] cnt,
  output logic [LEVELS-1:0][CW-1:0] reload,
  output logic [CTRL_W-1:0]         ctrlReg
);
  logic [LEVELS-1:0][AW-1:0] startAddr;
  logic [AW-1:0]             pcPlus;
  regGroup_e                 wrGrp;
  regGroup_e                 rdGrp;
  logic [1:0]                rdLvl;
  logic                      rdLvlOk;

  assign pcPlus  = pc + AW'(STEP);
  assign wrGrp   = regGroup_e'(wrSel[SEL_W-1:2]);
  assign rdGrp   = regGroup_e'(rdSel[SEL_W-1:2]);
  assign rdLvl   = rdSel[1:0];
  assign rdLvlOk = (rdLvl < 2'(LEVELS));

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : gLevel
      logic hitLvl;
      logic fastAny;
      logic loopHere;
      assign hitLvl   = wrEn && (wrSel[1:0] == 2'(g));
      assign fastAny  = hitLvl && (wrGrp == GRP_FAST_MULTI || wrGrp == GRP_FAST_SINGLE);
      assign loopHere = (strb.cntIdx == 2'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          startAddr[g] <= '0;
          endAddr[g]   <= '0;
          cnt[g]       <= '0;
          reload[g]    <= '0;
        end else begin
          if (hitLvl && wrGrp == GRP_START) startAddr[g] <= AW'(wrData);
          else if (fastAny)                 startAddr[g] <= pcPlus;

          if (hitLvl && wrGrp == GRP_END)                  endAddr[g] <= AW'(wrData);
          else if (hitLvl && wrGrp == GRP_FAST_SINGLE)     endAddr[g] <= pcPlus;

          if ((hitLvl && wrGrp == GRP_RELOAD) || fastAny) reload[g] <= CW'(wrData);

          if ((hitLvl && wrGrp == GRP_COUNT) || fastAny)  cnt[g] <= CW'(wrData);
          else if (strb.decCnt && loopHere)               cnt[g] <= cnt[g] - CW'(1);
          else if (strb.reloadCnt && loopHere)            cnt[g] <= reload[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrlReg <= '0;
    else if (wrEn && wrGrp == GRP_CTRL && wrSel[1:0] == 2'd0) ctrlReg <= wrData[CTRL_W-1:0];
  end

  always_comb begin
    rdData = '0;
    case (rdGrp)
      GRP_START:  if (rdLvlOk) rdData = DW'(startAddr[rdLvl]);
      GRP_END:    if (rdLvlOk) rdData = DW'(endAddr[rdLvl]);
      GRP_COUNT:  if (rdLvlOk) rdData = DW'(cnt[rdLvl]);
      GRP_RELOAD: if (rdLvlOk) rdData = DW'(reload[rdLvl]);
      GRP_CTRL:   if (rdLvl == 2'd0) rdData = DW'(ctrlReg);
      default:    rdData = '0;
    endcase
  end

  assign nextPc = strb.redirect ? startAddr[strb.level] : pcPlus;
endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
  import lpseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int DW   = 32,
  parameter int STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    pc,
  output logic [AW-1:0]    nextPc,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [DW-1:0]    wrData,
  input  logic [SEL_W-1:0] rdSel,
  output logic [DW-1:0]    rdData
);
  seqStrobe_t                strb;
  logic [LEVELS-1:0][AW-1:0] endAddr;
  logic [LEVELS-1:0][CW-1:0] cnt;
  logic [LEVELS-1:0][CW-1:0] reload;
  logic [CTRL_W-1:0]         ctrlReg;

  lpseq_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .pc(pc), .endAddr(endAddr), .cnt(cnt), .ctrlReg(ctrlReg), .strb(strb)
  );

  lpseq_regs #(.AW(AW), .CW(CW), .DW(DW), .STEP(STEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .pc(pc), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .strb(strb), .nextPc(nextPc),
    .rdData(rdData), .endAddr(endAddr), .cnt(cnt), .reload(reload),
    .ctrlReg(ctrlReg)
  );
endmodule

// File: rtl/lpseq_checker.sv
module lpseq_checker
  import lpseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int STEP = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [AW-1:0]             pc,
  input logic [AW-1:0]             nextPc,
  input logic                      wrEn,
  input seqStrobe_t                strb,
  input logic [LEVELS-1:0][CW-1:0] cnt,
  input logic [LEVELS-1:0][CW-1:0] reload
);
  assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.redirect |-> nextPc == pc + AW'(STEP));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.decCnt && !strb.reloadCnt && !wrEn) |=> $stable(cnt));

  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.decCnt && !wrEn) |=> cnt[$past(strb.cntIdx)] == $past(cnt[strb.cntIdx]) - CW'(1));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.decCnt, strb.reloadCnt}));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.reloadCnt && !wrEn) |=> cnt[$past(strb.cntIdx)] == $past(reload[strb.cntIdx]));
endmodule

bind loop_sequencer lpseq_checker #(.AW(AW), .CW(CW), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .nextPc(nextPc), .wrEn(wrEn),
  .strb(strb), .cnt(cnt), .reload(reload)
);

// File: tb/loop_sequencer_tb.sv
`timescale 1ns/1ps
module loop_sequencer_tb;
  localparam int S_START = 0, S_END = 4, S_CNT = 8, S_REL = 12, S_CTRL = 16;
  localparam int S_FM = 20, S_FS = 24;
  localparam logic [31:0] PARK = 32'hF000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = PARK;
  logic [31:0] nextPc;
  logic        wrEn = 1'b0;
  logic [4:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [4:0]  rdSel = '0;
  logic [31:0] rdData;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  loop_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .nextPc(nextPc), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 5'(s); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input int s, input logic [31:0] exp);
    rdSel = 5'(s);
    #0.5;
    chk(req, rdData, exp);
  endtask

  // present pc, check nextPc, then let one clock edge pass
  task automatic stepChk(input string req, input logic [31:0] p, input logic [31:0] expNext);
    pc = p;
    #1;
    chk(req, nextPc, expNext);
    @(negedge clk);
  endtask

  task automatic clearAll();
    pc = PARK;
    wr(S_CTRL, 0);
    for (int l = 0; l < 3; l++) begin
      wr(S_START + l, 0); wr(S_END + l, 0); wr(S_CNT + l, 0); wr(S_REL + l, 0);
    end
  endtask

  task automatic t_reset();
    for (int l = 0; l < 3; l++) begin
      rdChk("R1 start", S_START + l, 0);
      rdChk("R1 end", S_END + l, 0);
      rdChk("R1 count", S_CNT + l, 0);
      rdChk("R1 reload", S_REL + l, 0);
    end
    rdChk("R1 ctrl", S_CTRL, 0);
    pc = 32'h100; #1;
    chk("R1 nextPc", nextPc, 32'h108);
    pc = PARK;
  endtask

  task automatic t_readWrite();
    for (int l = 0; l < 3; l++) begin
      wr(S_START + l, 32'h1111_0000 + l);
      wr(S_END + l, 32'h2222_0000 + l);
      wr(S_CNT + l, 32'h3333_0000 + l);
      wr(S_REL + l, 32'h4444_0000 + l);
    end
    for (int l = 0; l < 3; l++) begin
      rdChk("R2 start", S_START + l, 32'h1111_0000 + l);
      rdChk("R2 end", S_END + l, 32'h2222_0000 + l);
      rdChk("R2 count", S_CNT + l, 32'h3333_0000 + l);
      rdChk("R2 reload", S_REL + l, 32'h4444_0000 + l);
    end
    wr(S_CTRL, 32'hFFFF_FFFF);
    rdChk("R2 ctrl width", S_CTRL, 32'h0000_0FFF);
    clearAll();
  endtask

  task automatic t_basicLoop();
    wr(S_START, 32'h1000); wr(S_END, 32'h1010);
    wr(S_CNT, 2); wr(S_REL, 2);
    wr(S_CTRL, 32'h9);
    stepChk("R3 seq", 32'h1008, 32'h1010);
    rdChk("R3 count kept", S_CNT, 2);
    stepChk("R4 redirect1", 32'h1010, 32'h1000);
    rdChk("R4 dec1", S_CNT, 1);
    stepChk("R4 redirect2", 32'h1010, 32'h1000);
    rdChk("R4 dec2", S_CNT, 0);
    stepChk("R5 fall", 32'h1010, 32'h1018);
    rdChk("R5 reload", S_CNT, 2);
    pc = PARK;
    clearAll();
  endtask

  task automatic t_crossLink();
    wr(S_START + 1, 32'h2000); wr(S_END + 1, 32'h2040);
    wr(S_CNT + 2, 1);
    wr(S_CTRL, 32'hB0);
    stepChk("R6 redirect via counter 2", 32'h2040, 32'h2000);
    rdChk("R6 counter 2 dec", S_CNT + 2, 0);
    rdChk("R6 counter 1 untouched", S_CNT + 1, 0);
    pc = PARK;
    clearAll();
  endtask

  task automatic t_inactive();
    wr(S_START, 32'h7000); wr(S_END, 32'h7010); wr(S_CNT, 3);
    wr(S_CTRL, 32'h1);
    stepChk("R7 enable clear", 32'h7010, 32'h7018);
    rdChk("R7 count kept a", S_CNT, 3);
    pc = PARK;
    wr(S_CTRL, 32'hC);
    stepChk("R7 link 100", 32'h7010, 32'h7018);
    rdChk("R7 count kept b", S_CNT, 3);
    pc = PARK;
    wr(S_CTRL, 32'h8);
    stepChk("R7 link 000", 32'h7010, 32'h7018);
    rdChk("R7 count kept c", S_CNT, 3);
    pc = PARK;
    clearAll();
  endtask

  task automatic t_priority();
    wr(S_START, 32'h3100); wr(S_START + 1, 32'h3200);
    wr(S_END, 32'h3000); wr(S_END + 1, 32'h3000);
    wr(S_CNT, 1); wr(S_CNT + 1, 1);
    wr(S_CTRL, 32'hA9);
    stepChk("R8 lowest wins", 32'h3000, 32'h3100);
    rdChk("R8 counter 0 dec", S_CNT, 0);
    rdChk("R8 counter 1 kept", S_CNT + 1, 1);
    stepChk("R8 level 0 still owns match", 32'h3000, 32'h3008);
    rdChk("R8 counter 1 kept after fall", S_CNT + 1, 1);
    pc = PARK;
    clearAll();
  endtask

  task automatic t_fastMulti();
    wr(S_END + 2, 32'h4ABC);
    pc = 32'h4000;
    wr(S_FM + 2, 5);
    pc = PARK;
    rdChk("R9 start", S_START + 2, 32'h4008);
    rdChk("R9 reload", S_REL + 2, 5);
    rdChk("R9 count", S_CNT + 2, 5);
    rdChk("R9 end kept", S_END + 2, 32'h4ABC);
    clearAll();
  endtask

  task automatic t_fastSingle();
    pc = 32'h5000;
    wr(S_FS + 1, 3);
    pc = PARK;
    rdChk("R10 start", S_START + 1, 32'h5008);
    rdChk("R10 end", S_END + 1, 32'h5008);
    rdChk("R10 count", S_CNT + 1, 3);
    wr(S_CTRL, 32'hA0);
    for (int k = 0; k < 3; k++) stepChk("R10 repeat", 32'h5008, 32'h5008);
    stepChk("R10 exit", 32'h5008, 32'h5010);
    rdChk("R10 reload", S_CNT + 1, 3);
    pc = PARK;
    clearAll();
  endtask

  task automatic t_conflictAndIgnored();
    wr(S_START, 32'h6000); wr(S_END, 32'h6010); wr(S_CNT, 4);
    wr(S_CTRL, 32'h9);
    @(negedge clk);
    pc = 32'h6010; wrEn = 1'b1; wrSel = 5'(S_CNT); wrData = 9;
    #1;
    chk("R11 redirect during write", nextPc, 32'h6000);
    @(negedge clk);
    wrEn = 1'b0; pc = PARK;
    rdChk("R11 write wins", S_CNT, 9);
    wr(3, 32'hDEAD);
    wr(S_CTRL + 1, 32'hDEAD);
    wr(28, 32'hDEAD);
    rdChk("R11 start0 kept", S_START, 32'h6000);
    rdChk("R11 end0 kept", S_END, 32'h6010);
    rdChk("R11 count0 kept", S_CNT, 9);
    rdChk("R11 ctrl kept", S_CTRL, 32'h9);
    rdChk("R11 empty code reads zero", 3, 0);
    rdChk("R11 fast code reads zero", S_FM, 0);
    clearAll();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readWrite();
    t_basicLoop();
    t_crossLink();
    t_inactive();
    t_priority();
    t_fastMulti();
    t_fastSingle();
    t_conflictAndIgnored();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule